// File: doc/BRIEF.md
# Endpoint Transaction Status Bank

The block holds one status byte for each of sixteen endpoints: control OUT, control IN and endpoints 1 to 14. Each completed transaction on an endpoint writes its result into that endpoint's byte: success flag, error code and, on success, the data toggle. If the previous result has not been read when a new one arrives, a sticky overrun flag is raised.

A microcontroller drives command bytes into the block. A read command returns the selected status byte on the next cycle and clears its unread state. Buffer validate and buffer clear commands are passed on as one-cycle pulses. A received SETUP packet locks those buffer commands for both control endpoints. The lock stays until an acknowledge command releases it. While the lock holds, a blocked command raises an ignored pulse and produces no buffer pulse.

Top module: `ep_status_bank`

## Requirements
- R1: After reset every status byte is 0, the control lock is 0, and every output is 0.
- R2: Status byte layout: bit 7 overrun, bit 6 data toggle (0 = DATA0, 1 = DATA1), bit 5 always 0, bits 4:1 error code, bit 0 success.
- R3: A transaction done strobe on endpoint index E overwrites E's error code and success bits with the values presented in that cycle.
- R4: The toggle bit takes `xfer_tog_i` only when `xfer_ok_i` is 1. A failed transaction leaves the toggle bit unchanged.
- R5: A transaction on an endpoint whose previous result is still unread sets that endpoint's overrun bit. The bit stays set until the endpoint is read.
- R6: Command bytes 0xA0 to 0xAF select endpoint index = low nibble (0 control OUT, 1 control IN, 2 to 15 endpoints 1 to 14). The next cycle pulses `rd_valid_o` and presents the byte as it stood before that cycle's update. `rd_data_o` holds between reads.
- R7: A read clears the endpoint's overrun bit and its unread state. A transaction on the same endpoint in the same cycle as the read leaves it unread, with overrun 0.
- R8: `setup_rx_i` sets `ctrl_lock_o` on the next cycle. Command 0xF4 clears it. If both occur in the same cycle, the lock is set.
- R9: Command 0x6E (E = endpoint index in the low nibble) pulses `buf_validate_o`, and 0x7E pulses `buf_clear_o`, on the next cycle with `buf_ep_o` = E, provided the command is not blocked.
- R10: While `ctrl_lock_o` is 1, a validate or clear command to index 0 or 1 produces a `cmd_ignored_o` pulse on the next cycle and no buffer pulse. Indices 2 to 15 are unaffected by the lock.
- R11: Any other command byte pulses no output and leaves the lock unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xfer_done_i | input | 1 | Transaction completed strobe |
| xfer_ep_i | input | 4 | Endpoint index of the completed transaction |
| xfer_ok_i | input | 1 | Transaction succeeded |
| xfer_err_i | input | 4 | Error code of the transaction |
| xfer_tog_i | input | 1 | PID toggle of the packet (1 = DATA1) |
| setup_rx_i | input | 1 | SETUP packet received pulse |
| cmd_valid_i | input | 1 | Command byte strobe |
| cmd_byte_i | input | 8 | Command byte |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 8 | Status byte returned by a read |
| buf_validate_o | output | 1 | Accepted validate buffer pulse |
| buf_clear_o | output | 1 | Accepted clear buffer pulse |
| buf_ep_o | output | 4 | Endpoint index of the last accepted buffer command |
| cmd_ignored_o | output | 1 | Buffer command blocked by the control lock |
| ctrl_lock_o | output | 1 | Control endpoint buffer commands locked |

## Verification
The assertions check the per-cycle rules on every cycle: field capture, toggle hold on failure, overrun set, read clear, lock set and release, blocking of control commands, the zero reserved bit, and silence after unknown commands. Some behaviours depend on event order, and only the bench scenarios show them. These are a read racing a transaction on the same endpoint, a setup racing an acknowledge, and a full sweep that reads every endpoint after mixed traffic. In those scenarios a reference model checks the returned bytes.

// File: rtl/ep_status_pkg.sv
package ep_status_pkg;
  localparam int unsigned EP_W     = 4;
  localparam int unsigned ERR_W    = 4;
  localparam int unsigned CTRL_EPS = 2;
  localparam logic [3:0] OP_READ   = 4'hA;
  localparam logic [3:0] OP_VALID  = 4'h6;
  localparam logic [3:0] OP_CLEAR  = 4'h7;
  localparam logic [7:0] OP_ACK    = 8'hF4;

  typedef struct packed {
    logic             ovr;
    logic             tog;
    logic             rsvd;
    logic [ERR_W-1:0] err;
    logic             ok;
  } stat_t;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_VALID, CMD_CLEAR, CMD_ACK
  } cmd_e;
endpackage

// File: rtl/ep_cmd_decode.sv
module ep_cmd_decode
  import ep_status_pkg::*;
(
  input  logic            cmd_valid_i,
  input  logic [7:0]      cmd_byte_i,
  output cmd_e            kind_o,
  output logic [EP_W-1:0] ep_o
);
  always_comb begin
    kind_o = CMD_NONE;
    ep_o   = cmd_byte_i[EP_W-1:0];
    if (cmd_valid_i) begin
      if (cmd_byte_i == OP_ACK)              kind_o = CMD_ACK;
      else if (cmd_byte_i[7:4] == OP_READ)   kind_o = CMD_READ;
      else if (cmd_byte_i[7:4] == OP_VALID)  kind_o = CMD_VALID;
      else if (cmd_byte_i[7:4] == OP_CLEAR)  kind_o = CMD_CLEAR;
    end
  end
endmodule

// File: rtl/ep_setup_lock.sv
module ep_setup_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic setup_i,
  input  logic ack_i,
  output logic lock_o
);
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lock_q <= 1'b0;
    else if (setup_i) lock_q <= 1'b1;   // setup wins over ack
    else if (ack_i)   lock_q <= 1'b0;
  end

  assign lock_o = lock_q;

  assert_setup_locks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_i |=> lock_o);
  assert_ack_unlocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !setup_i |=> !lock_o);
endmodule

// File: rtl/ep_status_slot.sv
module ep_status_slot
  import ep_status_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rec_i,
  input  logic             ok_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             tog_i,
  input  logic             rd_clr_i,
  output stat_t            stat_o
);
  logic             pend_q, ovr_q, tog_q, ok_q;
  logic [ERR_W-1:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      tog_q  <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= '0;
    end else begin
      if (rec_i) begin
        err_q <= err_i;
        ok_q  <= ok_i;
        if (ok_i) tog_q <= tog_i;
      end
      if (rd_clr_i) begin
        pend_q <= rec_i;   // result arriving with the read stays unread
        ovr_q  <= 1'b0;
      end else if (rec_i) begin
        pend_q <= 1'b1;
        if (pend_q) ovr_q <= 1'b1;
      end
    end
  end

  always_comb begin
    stat_o      = '0;
    stat_o.ovr  = ovr_q;
    stat_o.tog  = tog_q;
    stat_o.err  = err_q;
    stat_o.ok   = ok_q;
  end

  assert_fields_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i |=> stat_o.err == $past(err_i) && stat_o.ok == $past(ok_i));
  assert_tog_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i && !ok_i |=> $stable(stat_o.tog));
  assert_overrun_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i && pend_q && !rd_clr_i |=> stat_o.ovr);
  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr_i |=> !stat_o.ovr);
endmodule

// File: rtl/ep_status_bank.sv
module ep_status_bank
  import ep_status_pkg::*;
#(
  parameter int unsigned NUM_EP = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xfer_done_i,
  input  logic [EP_W-1:0]  xfer_ep_i,
  input  logic             xfer_ok_i,
  input  logic [ERR_W-1:0] xfer_err_i,
  input  logic             xfer_tog_i,
  input  logic             setup_rx_i,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_byte_i,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  output logic             buf_validate_o,
  output logic             buf_clear_o,
  output logic [EP_W-1:0]  buf_ep_o,
  output logic             cmd_ignored_o,
  output logic             ctrl_lock_o
);
  cmd_e            kind;
  logic [EP_W-1:0] cmd_ep;
  stat_t           stat_arr [NUM_EP];
  stat_t           sel_stat;
  logic            lock, is_ctrl, is_buf, blocked;

  ep_cmd_decode i_dec (
    .cmd_valid_i (cmd_valid_i),
    .cmd_byte_i  (cmd_byte_i),
    .kind_o      (kind),
    .ep_o        (cmd_ep)
  );

  ep_setup_lock i_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .setup_i (setup_rx_i),
    .ack_i   (kind == CMD_ACK),
    .lock_o  (lock)
  );

  for (genvar g = 0; g < NUM_EP; g++) begin : g_slot
    ep_status_slot i_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rec_i    (xfer_done_i && (xfer_ep_i == EP_W'(g))),
      .ok_i     (xfer_ok_i),
      .err_i    (xfer_err_i),
      .tog_i    (xfer_tog_i),
      .rd_clr_i ((kind == CMD_READ) && (cmd_ep == EP_W'(g))),
      .stat_o   (stat_arr[g])
    );
  end

  always_comb begin
    sel_stat = '0;
    for (int i = 0; i < NUM_EP; i++)
      if (cmd_ep == EP_W'(i)) sel_stat = stat_arr[i];
  end

  assign is_ctrl = cmd_ep < EP_W'(CTRL_EPS);
  assign is_buf  = (kind == CMD_VALID) || (kind == CMD_CLEAR);
  assign blocked = lock && is_ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o     <= 1'b0;
      rd_data_o      <= '0;
      buf_validate_o <= 1'b0;
      buf_clear_o    <= 1'b0;
      buf_ep_o       <= '0;
      cmd_ignored_o  <= 1'b0;
    end else begin
      rd_valid_o     <= kind == CMD_READ;
      if (kind == CMD_READ) rd_data_o <= sel_stat;
      buf_validate_o <= (kind == CMD_VALID) && !blocked;
      buf_clear_o    <= (kind == CMD_CLEAR) && !blocked;
      cmd_ignored_o  <= is_buf && blocked;
      if (is_buf && !blocked) buf_ep_o <= cmd_ep;
    end
  end

  assign ctrl_lock_o = lock;

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !rd_data_o[5]);
  assert_rd_after_cmd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_byte_i[7:4] == OP_READ |=> rd_valid_o && !buf_validate_o && !buf_clear_o);
  assert_buf_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_byte_i[7:4] == OP_VALID && !ctrl_lock_o |=> buf_validate_o && !cmd_ignored_o);
  assert_lock_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && (cmd_byte_i[7:4] == OP_VALID || cmd_byte_i[7:4] == OP_CLEAR)
      && ctrl_lock_o && cmd_byte_i[3:0] < 4'd2
    |=> cmd_ignored_o && !buf_validate_o && !buf_clear_o);
  assert_unknown_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && kind == CMD_NONE && !setup_rx_i
    |=> !rd_valid_o && !buf_validate_o && !buf_clear_o && !cmd_ignored_o
        && ctrl_lock_o == $past(ctrl_lock_o));
endmodule

// File: tb/test_ep_status_bank.sv
`timescale 1ns/1ps
module test_ep_status_bank;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       xfer_done_i = 0, xfer_ok_i = 0, xfer_tog_i = 0, setup_rx_i = 0, cmd_valid_i = 0;
  logic [3:0] xfer_ep_i = 0, xfer_err_i = 0;
  logic [7:0] cmd_byte_i = 0;
  logic       rd_valid_o, buf_validate_o, buf_clear_o, cmd_ignored_o, ctrl_lock_o;
  logic [7:0] rd_data_o;
  logic [3:0] buf_ep_o;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";

  always #4 clk_i = ~clk_i;

  ep_status_bank i_ep_status_bank (.*);

  // reference model
  bit       m_pend[16], m_ovr[16], m_tog[16], m_ok[16];
  bit [3:0] m_err[16];
  bit       m_lock, e_rd_valid, e_val, e_clr, e_ign;
  bit [7:0] e_rd_data;
  bit [3:0] e_ep;

  always @(posedge clk_i or negedge rst_ni) begin : model
    int ep; bit rd, val, clr, ack, ctl, recd, rdi;
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++) begin
        m_pend[i] = 0; m_ovr[i] = 0; m_tog[i] = 0; m_ok[i] = 0; m_err[i] = 0;
      end
      m_lock = 0; e_rd_valid = 0; e_val = 0; e_clr = 0; e_ign = 0; e_rd_data = 0; e_ep = 0;
    end else begin
      ep  = int'(cmd_byte_i[3:0]);
      ack = cmd_valid_i && cmd_byte_i == 8'hF4;
      rd  = cmd_valid_i && cmd_byte_i[7:4] == 4'hA;
      val = cmd_valid_i && cmd_byte_i[7:4] == 4'h6;
      clr = cmd_valid_i && cmd_byte_i[7:4] == 4'h7;
      ctl = ep < 2;
      e_rd_valid = rd;
      if (rd) e_rd_data = {m_ovr[ep], m_tog[ep], 1'b0, m_err[ep], m_ok[ep]};
      e_ign = (val || clr) && m_lock && ctl;
      e_val = val && !(m_lock && ctl);
      e_clr = clr && !(m_lock && ctl);
      if (e_val || e_clr) e_ep = cmd_byte_i[3:0];
      for (int i = 0; i < 16; i++) begin
        recd = xfer_done_i && int'(xfer_ep_i) == i;
        rdi  = rd && ep == i;
        if (recd) begin
          m_err[i] = xfer_err_i; m_ok[i] = xfer_ok_i;
          if (xfer_ok_i) m_tog[i] = xfer_tog_i;
        end
        if (rdi) begin m_ovr[i] = 0; m_pend[i] = recd; end
        else if (recd) begin if (m_pend[i]) m_ovr[i] = 1; m_pend[i] = 1; end
      end
      if (setup_rx_i) m_lock = 1; else if (ack) m_lock = 0;
    end
  end

  task automatic chk(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    chk("rd_valid", rd_valid_o, e_rd_valid);
    chk("rd_data", rd_data_o, e_rd_data);
    chk("validate", buf_validate_o, e_val);
    chk("clear", buf_clear_o, e_clr);
    chk("buf_ep", buf_ep_o, e_ep);
    chk("ignored", cmd_ignored_o, e_ign);
    chk("lock", ctrl_lock_o, m_lock);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic drive(bit dn, bit [3:0] ep, bit ok, bit [3:0] err, bit tg,
                       bit su, bit cv, bit [7:0] cb);
    xfer_done_i = dn; xfer_ep_i = ep; xfer_ok_i = ok; xfer_err_i = err; xfer_tog_i = tg;
    setup_rx_i = su; cmd_valid_i = cv; cmd_byte_i = cb;
    @(negedge clk_i);
    xfer_done_i = 0; setup_rx_i = 0; cmd_valid_i = 0;
  endtask

  task automatic xfer(bit [3:0] ep, bit ok, bit [3:0] err, bit tg);
    drive(1, ep, ok, err, tg, 0, 0, 8'h00);
  endtask

  task automatic cmd(bit [7:0] cb);
    drive(0, 0, 0, 0, 0, 0, 1, cb);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    cur_req = "R1";
    idle(3);
    @(negedge clk_i) rst_ni = 1;
    idle(3);
    for (int i = 0; i < 16; i++) cmd(8'hA0 | 8'(i));

    cur_req = "R2";
    xfer(4'd3, 1, 4'h0, 1);
    cmd(8'hA3); idle(1);
    chk("R2 byte", rd_data_o, 8'h41);

    cur_req = "R3";
    xfer(4'd3, 0, 4'h5, 0);
    cmd(8'hA3); idle(1);
    chk("R3 byte", rd_data_o, 8'h4A);

    cur_req = "R4";
    xfer(4'd4, 1, 4'h0, 1);
    cmd(8'hA4);
    xfer(4'd4, 0, 4'h6, 0);
    cmd(8'hA4); idle(1);
    chk("R4 toggle kept", rd_data_o[6], 1);

    cur_req = "R5";
    xfer(4'd5, 1, 4'h0, 0);
    xfer(4'd5, 0, 4'h4, 1);
    cmd(8'hA5); idle(1);
    chk("R5 overrun", rd_data_o[7], 1);

    cur_req = "R7";
    cmd(8'hA5); idle(1);
    chk("R7 cleared", rd_data_o[7], 0);
    xfer(4'd6, 1, 4'h0, 1);
    drive(1, 4'd6, 0, 4'h3, 0, 0, 1, 8'hA6);
    cmd(8'hA6); idle(1);
    chk("R7 race pending no ovr", rd_data_o, 8'h46);
    xfer(4'd6, 1, 4'h0, 0);
    xfer(4'd6, 1, 4'h0, 1);
    cmd(8'hA6);

    cur_req = "R6";
    for (int i = 0; i < 16; i++) xfer(4'(i), 1'(i & 1), 4'(i % 7), 1'(i >> 1));
    xfer(4'd9, 0, 4'h2, 0);
    for (int i = 0; i < 16; i++) cmd(8'hA0 | 8'(i));
    idle(2);

    cur_req = "R9";
    cmd(8'h62); cmd(8'h71); cmd(8'h60); cmd(8'h7F);

    cur_req = "R8";
    drive(0, 0, 0, 0, 0, 1, 0, 0); idle(1);
    chk("R8 locked", ctrl_lock_o, 1);
    cmd(8'hF4);
    chk("R8 unlocked", ctrl_lock_o, 0);
    drive(0, 0, 0, 0, 0, 1, 1, 8'hF4);
    chk("R8 setup wins", ctrl_lock_o, 1);

    cur_req = "R10";
    cmd(8'h60); cmd(8'h71); cmd(8'h65); cmd(8'h70); cmd(8'h7E);
    idle(1);
    chk("R10 ep kept", buf_ep_o, 4'hE);

    cur_req = "R11";
    cmd(8'h00); cmd(8'hF3); cmd(8'hB0); cmd(8'hF5);
    chk("R11 lock kept", ctrl_lock_o, 1);
    cmd(8'hF4); cmd(8'hFF); cmd(8'h50); idle(2);
    chk("R11 lock stays clear", ctrl_lock_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule